// File: doc/BRIEF.md
# Flash Page-Mode Read Interface

This block is a clocked model of the host-facing read path of a parallel NOR flash part. It combines three chip-enable inputs, the output-enable, write-enable and reset/power-down strobes into one read qualifier. It serves array reads from a four-word page buffer, and it drives a 16-bit data bus whose tri-state drivers are replaced by a per-bit lane enable. A bit whose lane enable is low is driven as 0 on `data_o`.

A read is requested by pulsing `req_i` for one cycle with a byte address on `addr_i`. If the addressed page is the one held in the buffer, the word comes back on the next edge. Otherwise the buffer is reloaded from an internal array and `busy_o` stays high while the load stalls the request. `ready_o` pulses for one cycle when `data_o` carries the new result. The byte-mode pin picks 8-bit or 16-bit transfers. A separate status-read selector routes an external 8-bit status value onto the bus, with the float rule that applies while the write controller is busy.

Top module: `flash_page_rd`

## Requirements
- R1: The device counts as selected when `ce_i` (bit 2, bit 1, bit 0) is 000, or when bit 2 is 1 and bits 1 and 0 are not both 1. Every other code disables all lanes.
- R2: `lane_oe_o` is all zero whenever the device is deselected, `oe_ni` is 1, `rp_ni` is 0 or `we_ni` is 0. A read request is accepted only when none of these holds.
- R3: A request whose page is not buffered raises `busy_o` for exactly MISS_LAT cycles. `ready_o` rises MISS_LAT+1 edges after the request edge, and `busy_o` and `ready_o` are never high together.
- R4: A request whose page matches the valid stored tag produces `ready_o` on the first edge after the request edge, with no `busy_o`.
- R5: A page is four consecutive words (word address bits above bit 1 form the tag). Byte address bits [2:1] pick the word and, in byte mode, bit 0 picks the byte.
- R6: With `byte_ni` = 0, `lane_oe_o` is 16'h00FF. `data_o[7:0]` is the high byte of the word when `addr_i[0]` was 1 and the low byte when it was 0.
- R7: With `byte_ni` = 1, `lane_oe_o` is 16'hFFFF, `data_o` is the full word, and `addr_i[0]` has no effect on the result or on page hit detection.
- R8: With `stat_sel_i` = 1, `data_o[7:0]` carries `status_i`. Lanes are 16'h0080 while `wsm_busy_i` = 1 and 16'h00FF otherwise; the high byte always floats.
- R9: Any cycle with the device selected, `we_ni` = 0 and `rp_ni` = 1 invalidates the page tag, so the next read misses even to the same page.
- R10: `rp_ni` = 0 aborts a page load: `busy_o` and `ready_o` are low on the next cycle, and the tag is invalidated.
- R11: After `rst_ni` is released, `ready_o` and `busy_o` are 0, the held data is 0 and the first read misses.
- R12: The word at word index i (modulo 256) holds {i[7:0] ^ 8'h3C, i[7:0] ^ 8'h96}.
- R13: `req_i` is ignored while a page load is in progress, while `stat_sel_i` = 1 and while the read qualifier of R2 fails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 3 | Chip-enable inputs (bit 2, bit 1, bit 0) |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write strobe, active low |
| rp_ni | input | 1 | Reset/power-down, active low |
| byte_ni | input | 1 | 0 = byte mode, 1 = word mode |
| stat_sel_i | input | 1 | Route status onto the bus instead of array data |
| wsm_busy_i | input | 1 | Write controller busy |
| status_i | input | 8 | Status value for status reads |
| req_i | input | 1 | Read request pulse |
| addr_i | input | ADDR_W | Byte address |
| data_o | output | 16 | Read data, zero on floating bits |
| lane_oe_o | output | 16 | Per-bit drive enable |
| ready_o | output | 1 | One-cycle pulse when new read data is valid |
| busy_o | output | 1 | Page load in progress |

## Verification
The bench builds the block with ADDR_W = 9, which gives 256 words in 64 pages, and with MISS_LAT = 5 instead of the default 8. The short stall keeps miss latency checks cheap. It also places the load-complete edge only one cycle after the fourth buffer word is written, which exposes any off-by-one between buffer filling and result capture. The 64 pages let the bench switch among distinct tags and revisit an evicted page.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fill_st_e;

  localparam int unsigned PAGE_WORDS = 4;
  localparam int unsigned DATA_W     = 16;

  // Array content: derived from the word index, no table.
  function automatic logic [15:0] word_pattern(input logic [31:0] idx);
    logic [7:0] b;
    b = idx[7:0];
    return {b ^ 8'h3C, b ^ 8'h96};
  endfunction

endpackage

// File: rtl/frd_select.sv
module frd_select (
  input  logic [2:0] ce_i,
  input  logic       oe_ni,
  input  logic       we_ni,
  input  logic       rp_ni,
  output logic       sel_o,
  output logic       rd_en_o,
  output logic       wr_cyc_o
);
  logic all_low, hi_pair;

  assign all_low  = (ce_i == 3'b000);
  assign hi_pair  = ce_i[1] & ce_i[0];
  assign sel_o    = all_low | (ce_i[2] & ~hi_pair);
  assign rd_en_o  = sel_o & ~oe_ni & we_ni & rp_ni;
  assign wr_cyc_o = sel_o & ~we_ni & rp_ni;
endmodule

// File: rtl/frd_page_ctrl.sv
module frd_page_ctrl
  import flash_rd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned MISS_LAT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              req_i,
  input  logic              wr_cyc_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [15:0]       word_o,
  output logic              a0_o,
  output logic              ready_o,
  output logic              busy_o
);
  localparam int unsigned WADDR_W = ADDR_W - 1;
  localparam int unsigned WORDS   = 1 << WADDR_W;
  localparam int unsigned PAGE_W  = WADDR_W - 2;
  localparam int unsigned CNT_W   = $clog2(MISS_LAT + 1);

  // Backing array, computed contents.
  logic [15:0] rom_w [WORDS];
  for (genvar g = 0; g < WORDS; g++) begin : g_rom
    assign rom_w[g] = word_pattern(32'(g));
  end

  logic [WADDR_W-1:0] waddr;
  logic [1:0]         entry;
  logic [PAGE_W-1:0]  page;
  assign waddr = addr_i[ADDR_W-1:1];
  assign entry = waddr[1:0];
  assign page  = waddr[WADDR_W-1:2];

  fill_st_e          state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PAGE_W-1:0] tag_q, page_q;
  logic [1:0]        ent_q;
  logic              tag_vld_q, dirty_q, a0_q, ready_q;
  logic [15:0]       word_q;
  logic [15:0]       pbuf_q [PAGE_WORDS];
  logic              hit;

  assign hit = tag_vld_q && (tag_q == page);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      tag_q     <= '0;
      page_q    <= '0;
      ent_q     <= '0;
      tag_vld_q <= 1'b0;
      dirty_q   <= 1'b0;
      a0_q      <= 1'b0;
      ready_q   <= 1'b0;
      word_q    <= '0;
      for (int i = 0; i < PAGE_WORDS; i++) pbuf_q[i] <= '0;
    end else if (abort_i) begin
      state_q   <= ST_IDLE;
      tag_vld_q <= 1'b0;
      dirty_q   <= 1'b0;
      ready_q   <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      if (wr_cyc_i) tag_vld_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            a0_q   <= addr_i[0];
            ent_q  <= entry;
            page_q <= page;
            if (hit) begin
              word_q  <= pbuf_q[entry];
              ready_q <= 1'b1;
            end else begin
              state_q   <= ST_FILL;
              cnt_q     <= '0;
              dirty_q   <= 1'b0;
              tag_vld_q <= 1'b0;
            end
          end
        end
        ST_FILL: begin
          if (cnt_q < CNT_W'(PAGE_WORDS))
            pbuf_q[cnt_q[1:0]] <= rom_w[{page_q, cnt_q[1:0]}];
          if (wr_cyc_i) dirty_q <= 1'b1;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(MISS_LAT - 1)) begin
            state_q   <= ST_IDLE;
            tag_q     <= page_q;
            tag_vld_q <= ~(dirty_q | wr_cyc_i);
            // Bypass the buffer: its last entry may be written this edge.
            word_q    <= rom_w[{page_q, ent_q}];
            ready_q   <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign word_o  = word_q;
  assign a0_o    = a0_q;
  assign ready_o = ready_q;
  assign busy_o  = (state_q == ST_FILL);
endmodule

// File: rtl/frd_lane_mux.sv
module frd_lane_mux (
  input  logic        rd_view_i,
  input  logic        byte_ni,
  input  logic        stat_sel_i,
  input  logic        wsm_busy_i,
  input  logic [7:0]  status_i,
  input  logic [15:0] word_i,
  input  logic        a0_i,
  output logic [15:0] data_o,
  output logic [15:0] lane_oe_o
);
  logic [15:0] val, lanes;

  always_comb begin
    val   = '0;
    lanes = '0;
    if (rd_view_i) begin
      if (stat_sel_i) begin
        val   = {8'h00, status_i};
        lanes = wsm_busy_i ? 16'h0080 : 16'h00FF;
      end else if (!byte_ni) begin
        val   = {8'h00, a0_i ? word_i[15:8] : word_i[7:0]};
        lanes = 16'h00FF;
      end else begin
        val   = word_i;
        lanes = 16'hFFFF;
      end
    end
  end

  assign data_o    = val & lanes;
  assign lane_oe_o = lanes;
endmodule

// File: rtl/flash_page_rd.sv
module flash_page_rd
  import flash_rd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned MISS_LAT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        ce_i,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              rp_ni,
  input  logic              byte_ni,
  input  logic              stat_sel_i,
  input  logic              wsm_busy_i,
  input  logic [7:0]        status_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [15:0]       data_o,
  output logic [15:0]       lane_oe_o,
  output logic              ready_o,
  output logic              busy_o
);
  logic sel, rd_en, wr_cyc, req_q, a0;
  logic [15:0] word;

  frd_select u_sel (
    .ce_i     (ce_i),
    .oe_ni    (oe_ni),
    .we_ni    (we_ni),
    .rp_ni    (rp_ni),
    .sel_o    (sel),
    .rd_en_o  (rd_en),
    .wr_cyc_o (wr_cyc)
  );

  assign req_q = req_i & rd_en & ~stat_sel_i;

  frd_page_ctrl #(.ADDR_W(ADDR_W), .MISS_LAT(MISS_LAT)) u_page (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .abort_i  (~rp_ni),
    .req_i    (req_q),
    .wr_cyc_i (wr_cyc),
    .addr_i   (addr_i),
    .word_o   (word),
    .a0_o     (a0),
    .ready_o  (ready_o),
    .busy_o   (busy_o)
  );

  frd_lane_mux u_mux (
    .rd_view_i  (rd_en),
    .byte_ni    (byte_ni),
    .stat_sel_i (stat_sel_i),
    .wsm_busy_i (wsm_busy_i),
    .status_i   (status_i),
    .word_i     (word),
    .a0_i       (a0),
    .data_o     (data_o),
    .lane_oe_o  (lane_oe_o)
  );
endmodule

// File: rtl/flash_page_rd_chk.sv
module flash_page_rd_chk #(
  parameter int unsigned MISS_LAT = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  ce_i,
  input logic        oe_ni,
  input logic        we_ni,
  input logic        rp_ni,
  input logic        byte_ni,
  input logic        stat_sel_i,
  input logic        wsm_busy_i,
  input logic [15:0] lane_oe_o,
  input logic        ready_o,
  input logic        busy_o
);
  logic [15:0] busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_run <= '0;
    else if (busy_o) busy_run <= busy_run + 1'b1;
    else             busy_run <= '0;
  end

  AST_DESEL_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i[2] && ce_i != 3'b000) || (ce_i == 3'b111) |-> lane_oe_o == 16'h0); // R1

  AST_FLOAT_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_ni || !we_ni || !rp_ni) |-> lane_oe_o == 16'h0); // R2

  AST_BUSY_READY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ready_o); // R3

  AST_BUSY_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> busy_run < 16'(MISS_LAT)); // R3

  AST_BYTE_HIGH_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_ni |-> lane_oe_o[15:8] == 8'h0); // R6

  AST_STATUS_BUSY_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_sel_i && wsm_busy_i |-> (lane_oe_o & 16'hFF7F) == 16'h0); // R8

  AST_RP_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rp_ni |=> !busy_o && !ready_o); // R10
endmodule

bind flash_page_rd flash_page_rd_chk #(.MISS_LAT(MISS_LAT)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_i       (ce_i),
  .oe_ni      (oe_ni),
  .we_ni      (we_ni),
  .rp_ni      (rp_ni),
  .byte_ni    (byte_ni),
  .stat_sel_i (stat_sel_i),
  .wsm_busy_i (wsm_busy_i),
  .lane_oe_o  (lane_oe_o),
  .ready_o    (ready_o),
  .busy_o     (busy_o)
);

// File: tb/flash_page_rd_tb_top.sv
module flash_page_rd_tb_top;
  localparam int unsigned ADDR_W   = 9;
  localparam int unsigned MISS_LAT = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] ce_i = 3'b000;
  logic oe_ni = 1'b0, we_ni = 1'b1, rp_ni = 1'b1, byte_ni = 1'b1;
  logic stat_sel_i = 1'b0, wsm_busy_i = 1'b0, req_i = 1'b0;
  logic [7:0] status_i = 8'h00;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [15:0] data_o, lane_oe_o;
  logic ready_o, busy_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  flash_page_rd #(.ADDR_W(ADDR_W), .MISS_LAT(MISS_LAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce_i), .oe_ni(oe_ni), .we_ni(we_ni),
    .rp_ni(rp_ni), .byte_ni(byte_ni), .stat_sel_i(stat_sel_i),
    .wsm_busy_i(wsm_busy_i), .status_i(status_i), .req_i(req_i),
    .addr_i(addr_i), .data_o(data_o), .lane_oe_o(lane_oe_o),
    .ready_o(ready_o), .busy_o(busy_o)
  );

  function automatic logic [15:0] pat(input int unsigned w);
    logic [7:0] b;
    b = w[7:0];
    return {b ^ 8'h3C, b ^ 8'h96};
  endfunction

  function automatic logic [15:0] exp_data(input logic [ADDR_W-1:0] a, input logic bm_n);
    logic [15:0] w;
    w = pat(int'(a >> 1));
    if (bm_n) return w;
    return {8'h00, a[0] ? w[15:8] : w[7:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Issue a read and check latency and data.
  task automatic do_read(input logic [ADDR_W-1:0] a, input bit exp_hit, input string req);
    int n;
    @(negedge clk);
    addr_i = a;
    req_i  = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    n = 1;
    while (!ready_o && n < 40) begin
      @(negedge clk);
      n++;
    end
    check({req, " latency"}, n, exp_hit ? 1 : MISS_LAT + 1);
    check({req, " data"}, data_o, exp_data(a, byte_ni));
    check({req, " lanes"}, lane_oe_o, byte_ni ? 16'hFFFF : 16'h00FF);
  endtask

  task automatic t_reset;
    check("R11 ready after reset", ready_o, 0);
    check("R11 busy after reset", busy_o, 0);
    check("R11 data after reset", data_o, 16'h0);
  endtask

  task automatic t_word_page;
    byte_ni = 1'b1;
    do_read(9'h040, 0, "R11 R3 R12 first read miss");
    do_read(9'h042, 1, "R4 R5 hit word1");
    do_read(9'h046, 1, "R4 R5 hit word3");
    do_read(9'h047, 1, "R7 a0 ignored");
  endtask

  task automatic t_byte_mode;
    byte_ni = 1'b0;
    do_read(9'h045, 1, "R6 high byte");
    do_read(9'h044, 1, "R6 low byte");
    byte_ni = 1'b1;
  endtask

  task automatic t_page_switch;
    do_read(9'h080, 0, "R5 new page miss");
    do_read(9'h086, 1, "R5 new page hit");
    do_read(9'h040, 0, "R5 evicted page miss");
    do_read(9'h1FE, 0, "R12 top word");
  endtask

  task automatic t_write_inval;
    do_read(9'h1F8, 1, "R9 before write");
    @(negedge clk); we_ni = 1'b0;
    @(negedge clk); we_ni = 1'b1;
    do_read(9'h1F8, 0, "R9 same page after write");
  endtask

  task automatic t_rp;
    @(negedge clk); rp_ni = 1'b0;
    @(negedge clk);
    check("R2 lanes with rp low", lane_oe_o, 16'h0);
    rp_ni = 1'b1;
    do_read(9'h1F8, 0, "R10 miss after rp pulse");
    @(negedge clk); addr_i = 9'h010; req_i = 1'b1;
    @(negedge clk); req_i = 1'b0;
    @(negedge clk);
    check("R3 busy during load", busy_o, 1);
    rp_ni = 1'b0;
    @(negedge clk);
    check("R10 busy dropped", busy_o, 0);
    check("R10 no ready", ready_o, 0);
    rp_ni = 1'b1;
    for (int i = 0; i < MISS_LAT + 2; i++) begin
      @(negedge clk);
      if (ready_o) check("R10 stray ready", ready_o, 0);
    end
    do_read(9'h010, 0, "R10 aborted page misses");
  endtask

  task automatic t_ce_sweep;
    for (int c = 0; c < 8; c++) begin
      logic e;
      e = (c == 0) || (c >= 4 && c != 7);
      @(negedge clk); ce_i = 3'(c);
      #1;
      check($sformatf("R1 ce=%0d lanes", c), lane_oe_o, e ? 16'hFFFF : 16'h0);
    end
    @(negedge clk); ce_i = 3'b000;
  endtask

  task automatic t_float;
    @(negedge clk); oe_ni = 1'b1; #1;
    check("R2 oe high", lane_oe_o, 16'h0);
    check("R2 oe high data", data_o, 16'h0);
    oe_ni = 1'b0; we_ni = 1'b0; #1;
    check("R2 we low", lane_oe_o, 16'h0);
    @(negedge clk); we_ni = 1'b1;
  endtask

  task automatic t_status;
    @(negedge clk); stat_sel_i = 1'b1; wsm_busy_i = 1'b1; status_i = 8'hA5; #1;
    check("R8 busy lanes", lane_oe_o, 16'h0080);
    check("R8 busy data", data_o, 16'h0080);
    wsm_busy_i = 1'b0; #1;
    check("R8 idle lanes", lane_oe_o, 16'h00FF);
    check("R8 idle data", data_o, 16'h00A5);
    addr_i = 9'h100; req_i = 1'b1;
    @(negedge clk); req_i = 1'b0;
    check("R13 no load on status req", busy_o, 0);
    stat_sel_i = 1'b0;
  endtask

  task automatic t_ignore;
    @(negedge clk); ce_i = 3'b010; addr_i = 9'h120; req_i = 1'b1;
    @(negedge clk); req_i = 1'b0; ce_i = 3'b000;
    check("R13 deselected req", busy_o, 0);
    check("R13 deselected no ready", ready_o, 0);
    @(negedge clk); addr_i = 9'h130; req_i = 1'b1;
    @(negedge clk); addr_i = 9'h140;
    @(negedge clk); req_i = 1'b0;
    for (int i = 0; i < MISS_LAT; i++) begin
      if (ready_o) break;
      @(negedge clk);
    end
    check("R13 original result", data_o, pat(9'h130 >> 1));
    @(negedge clk);
    check("R13 single ready", ready_o, 0);
    check("R13 idle after load", busy_o, 0);
    do_read(9'h140, 0, "R13 ignored page not loaded");
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_word_page();
    t_byte_mode();
    t_page_switch();
    t_write_inval();
    t_rp();
    t_ce_sweep();
    t_float();
    t_status();
    t_ignore();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule